// File: doc/BRIEF.md
# Legacy Interrupt Pulse Aggregator

The block gathers four level-sensitive legacy interrupt lines onto one interrupt wire that an edge-triggered interrupt controller samples. Each line owns a pending flag. The flag is set when the line rises. Software reads and clears the flags through a small register port that has an address, a write strobe, write data and combinational read data.

Software has no way to see a level through a single pulse wire. It therefore writes the index of a line to an end-of-interrupt register once it has serviced that line. The block then looks at that line again. If the line is still high, the block raises its pending flag again and fires a new one-cycle pulse. The handler is entered again for as long as the device keeps its line asserted.

Register map: addresses 0 to 3 hold the status of lines 0 to 3, and address 4 is the end-of-interrupt register. In each status register, bit 0 is the pending flag.

Top module: `intx_pulse_merge`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending flag is cleared, `irq_pulse` is low and every status read returns 0, whatever the line levels are.
- R2: A 0-to-1 change on `intx_in[i]` sets pending flag i at the next clock edge. At that same edge `irq_pulse` goes high, and it stays high for exactly one cycle.
- R3: A read of address i (0 to 3) returns the pending flag of line i in bit 0, with every other bit 0. A read of address 4 or of any address above 4 returns 0.
- R4: A write to address i (0 to 3) with bit 0 of the data at 1 clears pending flag i. A write to that address with bit 0 at 0, including a write of zero, leaves the flag unchanged.
- R5: A write of value i (0 to 3) to address 4 while `intx_in[i]` is high sets pending flag i. If that flag was clear, the write also fires a one-cycle pulse at the edge that takes the write.
- R6: A write to address 4 does nothing if it names a line whose input is low, or if its value is 4 or more. Neither case sets a flag or fires a pulse.
- R7: A pulse fires only when a flag goes from clear to set. A new rising edge, or an end-of-interrupt re-check, on a line whose flag is already set produces no pulse.
- R8: Set requests from several lines in the same cycle produce a single one-cycle pulse, and every one of those flags becomes set.
- R9: If a clear write to line i and a set request for line i arrive in the same cycle, the set wins. The flag stays set and a pulse fires.
- R10: A line that is high when reset is released counts as a rising edge at the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| intx_in | input | 4 | Level-sensitive legacy interrupt lines, synchronous to clk |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_pulse | output | 1 | One-cycle interrupt pulse to the controller |

## Verification
Two functions can land in the same cycle. The first is a software clear of a line's flag together with a fresh rising edge on that same line. The bench provokes this by driving the edge and the clear write on the same falling clock edge. It then judges that the flag still reads 1 and that exactly one pulse appears. The second is several lines requesting at once. A sweep over all sixteen input patterns covers it: each pattern is applied in a single cycle, and the bench expects one pulse whenever the pattern is non-zero and a flag for every high line.

// File: rtl/intx_pkg.sv
package intx_pkg;

  // A flag is raised when its line was low last cycle and is high now.
  function automatic logic rise_of(input logic now_v, input logic last_v);
    return now_v & ~last_v;
  endfunction

  // Set has priority over clear.
  function automatic logic pend_next(input logic set_v, input logic pend_v,
                                     input logic clr_v);
    return set_v | (pend_v & ~clr_v);
  endfunction

  // A set counts as a clear-to-set change if the flag is clear or is being
  // cleared in the same cycle.
  function automatic logic fires(input logic set_v, input logic pend_v,
                                 input logic clr_v);
    return set_v & (~pend_v | clr_v);
  endfunction

endpackage

// File: rtl/intx_edge_detect.sv
module intx_edge_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_in,
  output logic [N-1:0] rise_o
);
  import intx_pkg::*;

  logic [N-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= lines_in;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise_o[g] = rise_of(lines_in[g], last_q[g]);
  end

endmodule

// File: rtl/intx_reg_decode.sv
module intx_reg_decode #(
  parameter int N      = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      eoi_o
);
  localparam logic [ADDR_W-1:0] EOI_ADDR = ADDR_W'(N);

  logic eoi_wr;
  assign eoi_wr = reg_wr && (reg_addr == EOI_ADDR);

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign clr_o[g] = reg_wr && (reg_addr == ADDR_W'(g)) && reg_wdata[0];
    assign eoi_o[g] = eoi_wr && (reg_wdata == DATA_W'(g));
  end

endmodule

// File: rtl/intx_pending_bank.sv
module intx_pending_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic         fire_o
);
  import intx_pkg::*;

  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] fire_v;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign pend_d[g] = pend_next(set_i[g], pend_q[g], clr_i[g]);
    assign fire_v[g] = fires(set_i[g], pend_q[g], clr_i[g]);

    // R2
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> $past(set_i[g]));
    // R4
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[g]) |-> $past(clr_i[g]) && !$past(set_i[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign fire_o = |fire_v;

endmodule

// File: rtl/intx_pulse_merge.sv
module intx_pulse_merge #(
  parameter int N      = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      intx_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pulse
);
  logic [N-1:0] rise_w;
  logic [N-1:0] clr_w;
  logic [N-1:0] eoi_w;
  logic [N-1:0] set_req;
  logic [N-1:0] pend_w;
  logic         fire_w;
  logic         irq_q;
  logic         rd_bit;

  intx_edge_detect #(.N(N)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_in (intx_in),
    .rise_o   (rise_w)
  );

  intx_reg_decode #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .clr_o     (clr_w),
    .eoi_o     (eoi_w)
  );

  // An end-of-interrupt write re-checks only the line it names.
  assign set_req = rise_w | (eoi_w & intx_in);

  intx_pending_bank #(.N(N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_req),
    .clr_i  (clr_w),
    .pend_o (pend_w),
    .fire_o (fire_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire_w;
  end
  assign irq_pulse = irq_q;

  always_comb begin
    rd_bit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (reg_addr == ADDR_W'(i)) rd_bit = pend_w[i];
    end
  end
  assign reg_rdata = {{(DATA_W-1){1'b0}}, rd_bit};

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(set_req) != '0));
  // R8
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (pend_w != '0));
  // R6
  eoi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_w));
  // R3
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:1] == '0);

endmodule

// File: tb/intx_pulse_merge_bench.sv
`timescale 1ns/1ps
module intx_pulse_merge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_in = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intx_pulse_merge u_intx_pulse_merge (
    .clk(clk), .rst_n(rst_n), .intx_in(intx_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset with lines high
    intx_in = 4'b0101;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq_pulse}, 0);
    for (int a = 0; a < 4; a++) rd_chk("R1 status in reset", 4'(a), 0);
    // R10 release with lines high
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 pulse after release", {31'b0, irq_pulse}, 1);
    for (int a = 0; a < 4; a++) rd_chk("R10 captured", 4'(a), {31'b0, (a == 0 || a == 2)});
    idle();
    chk("R2 one cycle", {31'b0, irq_pulse}, 0);
    intx_in = 4'b0000;
    for (int a = 0; a < 4; a++) wr(4'(a), 32'h1);
    idle();

    // Sweep every input pattern
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      intx_in = 4'(p);
      @(negedge clk);
      chk("R8 merged pulse", {31'b0, irq_pulse}, {31'b0, (p != 0)});
      for (int a = 0; a < 4; a++) rd_chk("R2 flag set", 4'(a), {31'b0, p[a]});
      rd_chk("R3 eoi addr reads zero", 4'd4, 0);
      rd_chk("R3 unmapped reads zero", 4'd9, 0);
      idle();
      chk("R2 pulse ended", {31'b0, irq_pulse}, 0);
      // re-check while flags still set: no pulse
      for (int i = 0; i < 4; i++) begin
        wr(4'd4, 32'(i));
        chk("R7 eoi on set flag", {31'b0, irq_pulse}, 0);
      end
      // zero and bit0-clear writes keep flags
      for (int a = 0; a < 4; a++) begin
        wr(4'(a), 32'h0);
        wr(4'(a), 32'hFFFF_FFFE);
        rd_chk("R4 no-op write", 4'(a), {31'b0, p[a]});
      end
      for (int a = 0; a < 4; a++) begin
        wr(4'(a), 32'h1);
        rd_chk("R4 cleared", 4'(a), 0);
      end
      // out-of-range indices ignored
      wr(4'd4, 32'd4);
      chk("R6 index 4 ignored", {31'b0, irq_pulse}, 0);
      wr(4'd4, 32'h100);
      chk("R6 high index ignored", {31'b0, irq_pulse}, 0);
      for (int a = 0; a < 4; a++) rd_chk("R6 no flag", 4'(a), 0);
      // re-check each line
      for (int i = 0; i < 4; i++) begin
        wr(4'd4, 32'(i));
        if (p[i]) chk("R5 eoi refires", {31'b0, irq_pulse}, 1);
        else      chk("R6 eoi on low line", {31'b0, irq_pulse}, 0);
        rd_chk("R5 flag after eoi", 4'(i), {31'b0, p[i]});
        idle();
        chk("R5 pulse one cycle", {31'b0, irq_pulse}, 0);
      end
      for (int a = 0; a < 4; a++) wr(4'(a), 32'h1);
      intx_in = 4'b0000;
      idle();
    end

    // R7 re-rise while flag set
    @(negedge clk); intx_in = 4'b0010;
    @(negedge clk); chk("R2 line1 pulse", {31'b0, irq_pulse}, 1);
    intx_in = 4'b0000;
    @(negedge clk); intx_in = 4'b0010;
    @(negedge clk); chk("R7 re-rise no pulse", {31'b0, irq_pulse}, 0);
    rd_chk("R7 flag held", 4'd1, 1);
    intx_in = 4'b0000;
    idle();

    // R9 clear write and rising edge in one cycle
    @(negedge clk);
    intx_in = 4'b0010; reg_addr = 4'd1; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 pulse on clear+set", {31'b0, irq_pulse}, 1);
    rd_chk("R9 flag stays set", 4'd1, 1);
    idle();
    chk("R9 pulse one cycle", {31'b0, irq_pulse}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule